// File: doc/BRIEF.md
# Per-Pin Programmable Input Glitch Filter

This block cleans up one general-purpose input pin before it reaches on-chip logic. The raw pin level is brought into the main clock domain by a two-stage synchronizer. A stability filter then samples the synchronized level on a chosen sample strobe. It lets a new level through only when that level has been seen unchanged on a programmed number of consecutive strobes. Short pulses of either polarity are therefore discarded.

Seven shared dividers produce the sample strobes. Each divider is a counter in the main clock domain that emits a single-cycle enable every N main-clock cycles, where N is its own programmable value. The pin picks one of the seven strobes and a sample mode of 1, 2 or 3. A bypass control skips the filter and forwards the synchronized level. A faster strobe gives a shorter filter delay for the same sample mode. The delay has a phase uncertainty of one strobe period.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is low, the filtered output tracks the synchronized input and the stability count is zero. At reset release the output equals the pin level, which has been held for at least two cycles, with no filtering delay.
- R2: With `bypass` high, `pin_out` equals the value `pin_in` had two main-clock edges earlier. A step is visible after exactly two rising edges.
- R3: A divider whose value is N (1 or more) produces one sample strobe every N main-clock cycles. The filter's latency scales with N accordingly.
- R4: A divider value of 0 produces no strobe. A filter that selects it holds its output whatever the input does, and it resumes once the value is nonzero again.
- R5: With effective sample mode M and strobe period N, a pulse lasting M*N main-clock cycles or less never reaches the output.
- R6: Pulse rejection and pass-through behave the same for high-going and low-going pulses.
- R7: A level held for (M+1)*N cycles or more always reaches the output. After a step on `pin_in`, the output changes on rising edge n with M*N+3 <= n <= M*N+N+2, where n counts edges from the step. The level must be seen on M+1 consecutive strobes, and each strobe's phase adds up to one period.
- R8: `smode` is 2 bits wide. The values 1, 2 and 3 give M = 1, 2 and 3, and the value 0 behaves as M = 1.
- R9: `clk_sel` value i (0 to 6) selects divider i, whose value sits at bits [i*DIV_W +: DIV_W] of `div_val`. A select of 7 picks no strobe, so the output holds.
- R10: On any edge where `clk_sel` or `smode` differs from its value at the previous edge, the stability count restarts from zero, that edge's sample is discarded and the output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 1 | Raw asynchronous pin level |
| div_val | input | NUM_CLK*DIV_W | Packed divider values, divider i at [i*DIV_W +: DIV_W] |
| clk_sel | input | SEL_W | Strobe select for this pin |
| smode | input | 2 | Sample mode (0 or 1 gives 1, 2 gives 2, 3 gives 3) |
| bypass | input | 1 | Forward synchronized level, no filtering |
| pin_out | output | 1 | Filtered pin level |

## Verification
The checker watches four things on every cycle. The filtered level changes only on an edge that carries the selected strobe, and only once the count has reached the effective mode. The count never exceeds the mode. A configuration change always holds the output and clears the count. In bypass, the output equals the pin two edges earlier. The bench sweeps every mode against every divider with a distinct period. Only these scenarios can show the absolute latency window, the rejection and pass thresholds for both pulse polarities, a frozen output under a zero divider or an unused select, and the delayed flip after a mid-count mode change.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
   localparam int unsigned MODE_W = 2;
   typedef logic [MODE_W-1:0] smode_t;

   // mode 0 is folded onto the shortest filter setting
   function automatic smode_t eff_mode(input smode_t m);
      return (m == '0) ? smode_t'(1) : m;
   endfunction
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pgf_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/pgf_strobe_div.sv
module pgf_strobe_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   // >= guards against the divisor shrinking below the running count
   always_comb tick = (div != '0) && (cnt >= (div - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if ((div == '0) || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pgf_stab_core.sv
module pgf_stab_core
   import pgf_pkg::*;
#(
   parameter int unsigned CFG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             tick,
   input  smode_t           mode,
   input  logic [CFG_W-1:0] cfg,
   output logic             dout,
   output smode_t           cnt
);
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;

   always_comb cfg_chg = (cfg != cfg_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout  <= din;
         cnt   <= '0;
         cfg_q <= cfg;
      end else begin
         cfg_q <= cfg;
         if (cfg_chg) begin
            cnt <= '0;
         end else if (tick) begin
            if (din == dout) begin
               cnt <= '0;
            end else if (cnt >= mode) begin
               dout <= din;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
   import pgf_pkg::*;
#(
   parameter int unsigned NUM_CLK     = 7,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = (NUM_CLK > 1) ? $clog2(NUM_CLK + 1) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pin_in,
   input  logic [NUM_CLK*DIV_W-1:0] div_val,
   input  logic [SEL_W-1:0]         clk_sel,
   input  logic [MODE_W-1:0]        smode,
   input  logic                     bypass,
   output logic                     pin_out
);
   localparam int unsigned CFG_W = SEL_W + MODE_W;

   generate
      if (NUM_CLK < 1) begin : g_bad_clk
         $error("pin_glitch_filter: NUM_CLK must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("pin_glitch_filter: DIV_W must be at least 1");
      end
   endgenerate

   logic               sync_q;
   logic [NUM_CLK-1:0] ticks;
   logic               sel_tick;
   logic               filt_q;
   smode_t             stab_cnt;
   smode_t             eff_md;

   pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pin_in),
      .q   (sync_q)
   );

   generate
      for (genvar g = 0; g < NUM_CLK; g++) begin : g_div
         pgf_strobe_div #(.DIV_W(DIV_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .div   (div_val[g*DIV_W +: DIV_W]),
            .tick  (ticks[g])
         );
      end
   endgenerate

   always_comb begin
      sel_tick = 1'b0;
      for (int i = 0; i < NUM_CLK; i++) begin
         if (clk_sel == SEL_W'(i)) sel_tick = ticks[i];
      end
   end

   always_comb eff_md = eff_mode(smode);

   pgf_stab_core #(.CFG_W(CFG_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sync_q),
      .tick  (sel_tick),
      .mode  (eff_md),
      .cfg   ({clk_sel, smode}),
      .dout  (filt_q),
      .cnt   (stab_cnt)
   );

   assign pin_out = bypass ? sync_q : filt_q;
endmodule

// File: rtl/pin_glitch_filter_chk.sv
module pin_glitch_filter_chk #(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pin_in,
   input logic [SEL_W-1:0]  clk_sel,
   input logic [MODE_W-1:0] smode,
   input logic              bypass,
   input logic              pin_out,
   input logic              sel_tick,
   input logic              filt_q,
   input logic [MODE_W-1:0] stab_cnt,
   input logic [MODE_W-1:0] eff_md
);
   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
   end

   // R3/R4: output moves only on an edge that carried the selected strobe
   p_flip_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && filt_q != $past(filt_q)) |-> $past(sel_tick));

   // R7: a flip needs the full run of consecutive samples
   p_flip_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && filt_q != $past(filt_q)) |-> ($past(stab_cnt) == $past(eff_md)));

   // R10: the stability count stays within the effective mode
   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stab_cnt <= eff_md);

   // R10: a config change clears the count and holds the output
   p_cfg_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && {clk_sel, smode} != $past({clk_sel, smode}))
      |=> ($stable(filt_q) && stab_cnt == '0));

   // R2: bypass forwards the pin after two edges
   p_bypass_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && since_rst >= 2'd2) |-> (pin_out == $past(pin_in, 2)));
endmodule

bind pin_glitch_filter pin_glitch_filter_chk #(
   .SEL_W  (SEL_W),
   .MODE_W (pgf_pkg::MODE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_in   (pin_in),
   .clk_sel  (clk_sel),
   .smode    (smode),
   .bypass   (bypass),
   .pin_out  (pin_out),
   .sel_tick (sel_tick),
   .filt_q   (filt_q),
   .stab_cnt (stab_cnt),
   .eff_md   (eff_md)
);

// File: tb/pin_glitch_filter_test.sv
module pin_glitch_filter_test;
   localparam int NC = 7;
   localparam int DW = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           pin_in;
   logic [NC*DW-1:0] div_val;
   logic [2:0]     clk_sel;
   logic [1:0]     smode;
   logic           bypass;
   logic           pin_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pin_glitch_filter #(.NUM_CLK(NC), .DIV_W(DW), .SYNC_STAGES(2)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .div_val (div_val),
      .clk_sel (clk_sel),
      .smode   (smode),
      .bypass  (bypass),
      .pin_out (pin_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   // drive a step and count rising edges until the output follows
   task automatic step_meas(input bit v, input int lo, input int hi, input string req);
      int n = 0;
      pin_in = v;
      while (pin_out !== v && n < hi + 4) begin
         cyc(1);
         n++;
      end
      check(n >= lo && n <= hi, req, n, lo);
   endtask

   task automatic pulse(input bit v, input int len, input bit exp_pass, input int settle,
                        input string req);
      bit seen = 1'b0;
      pin_in = v;
      for (int i = 0; i < len; i++) begin
         cyc(1);
         if (pin_out === v) seen = 1'b1;
      end
      pin_in = !v;
      for (int i = 0; i < settle; i++) begin
         cyc(1);
         if (pin_out === v) seen = 1'b1;
      end
      check(seen == exp_pass, req, int'(seen), int'(exp_pass));
      check(pin_out === !v, req, int'(pin_out), int'(!v));
   endtask

   task automatic wait_follow(input int lim, input string req);
      int n = 0;
      while (pin_out !== pin_in && n < lim) begin
         cyc(1);
         n++;
      end
      check(pin_out === pin_in, req, int'(pin_out), int'(pin_in));
   endtask

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      pin_in  = 1'b0;
      bypass  = 1'b0;
      smode   = 2'd1;
      clk_sel = 3'd0;
      for (int i = 0; i < NC; i++) div_val[i*DW +: DW] = DW'(i + 1);
      @(negedge clk);
      cyc(5);
      rst_n = 1'b1;
      check(pin_out === 1'b0, "R1 low at release", int'(pin_out), 0);
      cyc(1);
      check(pin_out === 1'b0, "R1 low after release", int'(pin_out), 0);

      // reset with the pin high: output loads it with no filter delay
      pin_in = 1'b1;
      cyc(2);
      rst_n = 1'b0;
      cyc(4);
      rst_n = 1'b1;
      check(pin_out === 1'b1, "R1 high at release", int'(pin_out), 1);
      cyc(1);
      check(pin_out === 1'b1, "R1 high after release", int'(pin_out), 1);

      // R2 bypass
      bypass = 1'b1;
      step_meas(1'b0, 2, 2, "R2 bypass fall");
      step_meas(1'b1, 2, 2, "R2 bypass rise");
      bypass = 1'b0;
      cyc(20);
      wait_follow(20, "R2 settle after bypass");

      // sweep every mode against every divider (period sel+1)
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < NC; s++) begin
            int em;
            int n;
            bit cur;
            em = (m == 0) ? 1 : m;
            n  = s + 1;
            smode   = 2'(m);
            clk_sel = 3'(s);
            cyc(4);
            cur = pin_in;
            pulse(!cur, em*n, 1'b0, (em+2)*n + 4, "R5 reject");
            pulse(!cur, (em+1)*n, 1'b1, (em+2)*n + 4, "R7 pass");
            step_meas(!cur, em*n + 3, em*n + n + 2, "R3 R8 step latency");
            pulse(cur, em*n, 1'b0, (em+2)*n + 4, "R6 reject other polarity");
            pulse(cur, (em+1)*n, 1'b1, (em+2)*n + 4, "R6 pass other polarity");
            step_meas(cur, em*n + 3, em*n + n + 2, "R7 step latency");
         end
      end

      // R9 unused select freezes output
      smode   = 2'd1;
      clk_sel = 3'd7;
      cyc(4);
      begin
         bit v;
         v = !pin_in;
         pin_in = v;
         cyc(40);
         check(pin_out === !v, "R9 select 7 holds", int'(pin_out), int'(!v));
      end
      clk_sel = 3'd0;
      wait_follow(20, "R9 select 0 resumes");

      // R4 zero divider freezes output
      clk_sel = 3'd2;
      cyc(4);
      div_val[2*DW +: DW] = '0;
      begin
         bit v;
         v = !pin_in;
         pin_in = v;
         cyc(40);
         check(pin_out === !v, "R4 zero divider holds", int'(pin_out), int'(!v));
      end
      div_val[2*DW +: DW] = DW'(3);
      wait_follow(30, "R4 divider restored");

      // R10 mid-count mode change restarts the count
      smode   = 2'd3;
      clk_sel = 3'd3;
      cyc(4);
      begin
         bit v;
         int n;
         v = !pin_in;
         pin_in = v;
         n = 0;
         while (n < 11) begin
            cyc(1);
            n++;
         end
         check(pin_out === !v, "R10 not yet flipped", int'(pin_out), int'(!v));
         smode = 2'd2;
         while (pin_out !== v && n < 40) begin
            cyc(1);
            n++;
         end
         check(n >= 21 && n <= 24, "R10 restart latency", n, 21);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule